// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides the system clock into time quanta and walks each CAN bit through its four segments: a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. A single 32-bit timing word configures it. Every field in that word is stored as its value minus one, and the block clamps any value that falls outside the legal ranges. The outputs are a quantum tick, a sample strobe, a bit-start strobe, the current segment code and the sampled bus level. The sampled level is either a single sample or a majority vote of three samples.

A receive front end detects recessive-to-dominant transitions on the bus and pulses `resync_edge`. The generator records that pulse and applies it at the next quantum boundary. A pulse in the propagation segment or in phase 1 lengthens phase 1. A pulse in phase 2 shortens phase 2. Either change is limited to the jump width. The generator runs only while `enable` is high. It takes in the timing word only while `enable` is low, so software writes the timing word with the generator stopped.

Top module: `can_bit_timer`

## Requirements
- R1: The timing word holds phase 2 minus one in bits 2:0, phase 1 minus one in bits 6:4, propagation minus one in bits 10:8, jump width minus one in bits 13:12, prescaler minus one in bits 22:16 and triple sampling in bit 24. One bit lasts brp*(1+prop+ph1+ph2) clocks.
- R2: `tq_tick` is high for one clock in every brp clocks. A prescaler field of 0 is clamped to brp=2, and the largest field gives brp=128.
- R3: If prop+ph1 is below 4 quanta, ph1 is raised so that the sum equals 4. A phase 2 of 1 quantum is raised to 2.
- R4: `seg` reports the current segment as 0 for sync, 1 for propagation, 2 for phase 1 and 3 for phase 2. `bit_start` is high on the last clock of the sync quantum, and the propagation segment follows it.
- R5: In single mode `sample_strobe` pulses once per bit, on the last clock of phase 1, which is brp*(prop+ph1) clocks after `bit_start`. `sampled_bit` then takes the value of `rx_level` at that clock edge.
- R6: With bit 24 set, `sample_strobe` pulses on the last clock of each of the last three quanta before phase 2. `sampled_bit` becomes the majority of the three `rx_level` values taken at those strobes.
- R7: A `resync_edge` during the propagation segment or phase 1 lengthens phase 1 by min(q, sjw) quanta, where q is the index of the quantum in which the edge arrives (the sync quantum is 0). Only one adjustment is made per bit.
- R8: A `resync_edge` during phase 2 shortens phase 2 by min(r, sjw) quanta, where r is the number of phase 2 quanta still left after the current one. If r is not larger than sjw, the next bit starts right after the current quantum.
- R9: A `resync_edge` during the sync quantum has no effect.
- R10: While `enable` is low there are no ticks and `seg` is 0. The timing word is taken in only while `enable` is low, so changing it while enabled does not alter the bit length.
- R11: After reset, `seg` is 0, all strobes are low and `sampled_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; while low, the timing word is taken in |
| timing_word | input | 32 | Packed timing fields |
| rx_level | input | 1 | Bus level (0 = dominant) |
| resync_edge | input | 1 | One-clock pulse on a recessive-to-dominant transition |
| tq_tick | output | 1 | High on the last clock of each time quantum |
| sample_strobe | output | 1 | High on each clock where the bus is sampled |
| bit_start | output | 1 | High on the last clock of the sync quantum |
| seg | output | 2 | Current segment code |
| sampled_bit | output | 1 | Bit value decided at the sample point |

## Verification
The assertions check on every cycle the properties that follow the segment structure alone. Ticks are never back to back. The segment can change only on a tick. A bit start is always followed by the propagation segment. Phase 2 leaves only to sync. Strobes fall only in the propagation segment or phase 1. Disabling the generator parks it in sync. Only the bench scenarios can show the clock counts: the bit length and sample offset for a given timing word, the clamped values, the majority vote, and how much each resynchronisation edge lengthens or shortens a bit.

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] timing_word,
  input  logic        rx_level,
  input  logic        resync_edge,
  output logic        tq_tick,
  output logic        sample_strobe,
  output logic        bit_start,
  output logic [1:0]  seg,
  output logic        sampled_bit
);
  localparam int CW = 6;
  typedef enum logic [1:0] {S_SYNC = 2'd0, S_PROP = 2'd1, S_PH1 = 2'd2, S_PH2 = 2'd3} seg_t;

  logic [7:0]    brp_q, brp_n;
  logic [CW-1:0] prop_q, ph1_q, ph2_q, sjw_q;
  logic [CW-1:0] prop_n, ph1_n, ph2_n, sjw_n;
  logic          trip_q;
  logic [6:0]    pcnt;
  seg_t          seg_q;
  logic [CW-1:0] rem, qpos, ext_q, adj, rem_eff, left;
  logic          pend, done, use_rs, maj;
  logic [1:0]    hist;
  logic          unused_bits;

  assign unused_bits = ^{timing_word[31:25], timing_word[15:14], timing_word[11],
                         timing_word[7], timing_word[3]};

  always_comb begin
    brp_n = {1'b0, timing_word[22:16]} + 8'd1;
    if (brp_n < 8'd2) brp_n = 8'd2;
    prop_n = CW'(timing_word[10:8]) + CW'(1);
    ph1_n  = CW'(timing_word[6:4]) + CW'(1);
    if (prop_n + ph1_n < CW'(4)) ph1_n = CW'(4) - prop_n;
    ph2_n = CW'(timing_word[2:0]) + CW'(1);
    if (ph2_n < CW'(2)) ph2_n = CW'(2);
    sjw_n = CW'(timing_word[13:12]) + CW'(1);
  end

  assign tq_tick = enable && (pcnt == 7'(brp_q - 8'd1));
  assign use_rs  = pend && !done && (seg_q != S_SYNC);
  assign adj     = (use_rs && seg_q != S_PH2) ? ((qpos < sjw_q) ? qpos : sjw_q) : '0;
  assign rem_eff = (seg_q == S_PH1) ? rem + adj : rem;
  assign left    = (seg_q == S_PROP) ? rem + ph1_q + ext_q + adj :
                   (seg_q == S_PH1)  ? rem_eff : '0;
  assign sample_strobe = tq_tick && (left != '0) && (left <= (trip_q ? CW'(3) : CW'(1)));
  assign bit_start = tq_tick && (seg_q == S_SYNC);
  assign seg = seg_q;
  assign maj = (hist[1] & hist[0]) | (hist[1] & rx_level) | (hist[0] & rx_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brp_q <= 8'd2; prop_q <= CW'(1); ph1_q <= CW'(3); ph2_q <= CW'(2);
      sjw_q <= CW'(1); trip_q <= 1'b0;
      pcnt <= '0; seg_q <= S_SYNC; rem <= CW'(1); qpos <= '0; ext_q <= '0;
      pend <= 1'b0; done <= 1'b0; hist <= 2'b11; sampled_bit <= 1'b1;
    end else if (!enable) begin
      brp_q <= brp_n; prop_q <= prop_n; ph1_q <= ph1_n; ph2_q <= ph2_n;
      sjw_q <= sjw_n; trip_q <= timing_word[24];
      pcnt <= '0; seg_q <= S_SYNC; rem <= CW'(1); qpos <= '0; ext_q <= '0;
      pend <= 1'b0; done <= 1'b0;
    end else begin
      if (resync_edge) pend <= 1'b1;
      pcnt <= tq_tick ? '0 : pcnt + 7'd1;
      if (tq_tick) begin
        hist <= {hist[0], rx_level};
        qpos <= qpos + CW'(1);
        pend <= resync_edge;
        if (use_rs) done <= 1'b1;
        case (seg_q)
          S_SYNC: begin seg_q <= S_PROP; rem <= prop_q; end
          S_PROP: begin
            if (rem == CW'(1)) begin
              seg_q <= S_PH1;
              rem   <= ph1_q + ext_q + adj;
            end else begin
              rem <= rem - CW'(1);
              if (use_rs) ext_q <= adj;
            end
          end
          S_PH1: begin
            if (rem_eff == CW'(1)) begin
              seg_q <= S_PH2;
              rem   <= ph2_q;
              sampled_bit <= trip_q ? maj : rx_level;
            end else begin
              rem <= rem_eff - CW'(1);
            end
          end
          S_PH2: begin
            if (rem == CW'(1) || (use_rs && (rem - CW'(1)) <= sjw_q)) begin
              seg_q <= S_SYNC; rem <= CW'(1); qpos <= '0; ext_q <= '0; done <= 1'b0;
            end else begin
              rem <= use_rs ? rem - CW'(1) - sjw_q : rem - CW'(1);
            end
          end
          default: seg_q <= S_SYNC;
        endcase
      end
    end
  end
endmodule

// File: rtl/can_bit_timer_chk.sv
`timescale 1ns/1ps
module can_bit_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       tq_tick,
  input logic       sample_strobe,
  input logic       bit_start,
  input logic [1:0] seg
);
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |=> !tq_tick);
  assert_sync_to_prop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> seg == 2'd1);
  assert_seg_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tq_tick) |=> $stable(seg));
  assert_ph2_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && seg == 2'd3) |=> (seg == 2'd3 || seg == 2'd0));
  assert_strobe_in_tseg1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> (seg == 2'd1 || seg == 2'd2));
  assert_idle_in_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> seg == 2'd0);
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tq_tick(tq_tick),
  .sample_strobe(sample_strobe), .bit_start(bit_start), .seg(seg)
);

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, rx_level = 1'b1, resync_edge = 1'b0;
  logic [31:0] timing_word = '0;
  logic tq_tick, sample_strobe, bit_start, sampled_bit;
  logic [1:0] seg;
  int checks = 0, failures = 0;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .timing_word(timing_word),
    .rx_level(rx_level), .resync_edge(resync_edge), .tq_tick(tq_tick),
    .sample_strobe(sample_strobe), .bit_start(bit_start), .seg(seg),
    .sampled_bit(sampled_bit)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [31:0] mk(int brpf, int sjwf, int propf, int ph1f, int ph2f, bit trip);
    mk = '0;
    mk[22:16] = 7'(brpf); mk[13:12] = 2'(sjwf); mk[10:8] = 3'(propf);
    mk[6:4] = 3'(ph1f); mk[2:0] = 3'(ph2f); mk[24] = trip;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic configure(logic [31:0] w);
    @(negedge clk); enable = 1'b0; timing_word = w;
    repeat (2) @(negedge clk);
    enable = 1'b1;
  endtask

  // measures one bit from bit_start to the next; inj>=0 pulses resync in that segment
  task automatic run_bit(input int inj, input logic [2:0] pat,
                         output int per, output int soff, output int ns, output int seg1);
    int c; bit fired;
    per = 0; soff = -1; ns = 0; seg1 = -1; fired = 0; c = 0;
    while (!bit_start) @(negedge clk);
    do begin
      @(negedge clk); c++;
      resync_edge = 1'b0;
      if (c == 1) seg1 = int'(seg);
      if (sample_strobe) begin rx_level = pat[ns]; ns++; soff = c; end
      if (!fired && inj >= 0 && int'(seg) == inj) begin resync_edge = 1'b1; fired = 1; end
    end while (!bit_start && c < 5000);
    per = c;
  endtask

  task automatic t_reset;
    chk("R11 seg", int'(seg), 0);
    chk("R11 strobes", int'({tq_tick, sample_strobe, bit_start}), 0);
    chk("R11 sampled_bit", int'(sampled_bit), 1);
  endtask

  task automatic t_basic;
    int p, s, n, s1;
    configure(mk(3, 0, 1, 2, 2, 0));
    run_bit(-1, 3'b000, p, s, n, s1);
    run_bit(-1, 3'b000, p, s, n, s1);
    chk("R1 bit length", p, 36);
    chk("R5 sample offset", s, 20);
    chk("R5 strobe count", n, 1);
    chk("R4 seg after bit_start", s1, 1);
    chk("R5 sampled 0", int'(sampled_bit), 0);
    run_bit(-1, 3'b111, p, s, n, s1);
    chk("R5 sampled 1", int'(sampled_bit), 1);
  endtask

  task automatic t_clamp;
    int p, s, n, s1;
    configure(mk(0, 0, 0, 0, 0, 0));
    run_bit(-1, 3'b000, p, s, n, s1);
    run_bit(-1, 3'b000, p, s, n, s1);
    chk("R2 R3 clamped bit length", p, 14);
    chk("R3 clamped sample offset", s, 8);
  endtask

  task automatic t_max;
    int p, s, n, s1;
    configure(mk(127, 3, 7, 7, 7, 0));
    run_bit(-1, 3'b000, p, s, n, s1);
    run_bit(-1, 3'b000, p, s, n, s1);
    chk("R2 max bit length", p, 3200);
    chk("R1 max sample offset", s, 2048);
  endtask

  task automatic t_triple;
    int p, s, n, s1;
    configure(mk(3, 0, 1, 2, 2, 1));
    run_bit(-1, 3'b110, p, s, n, s1);
    run_bit(-1, 3'b110, p, s, n, s1);
    chk("R6 strobe count", n, 3);
    chk("R6 last strobe offset", s, 20);
    chk("R6 majority 0,1,1", int'(sampled_bit), 1);
    run_bit(-1, 3'b001, p, s, n, s1);
    chk("R6 majority 1,0,0", int'(sampled_bit), 0);
    run_bit(-1, 3'b101, p, s, n, s1);
    chk("R6 majority 1,0,1", int'(sampled_bit), 1);
  endtask

  task automatic t_resync_lengthen;
    int p, s, n, s1;
    configure(mk(3, 1, 1, 2, 2, 0));
    run_bit(2, 3'b000, p, s, n, s1);
    chk("R7 ph1 edge sjw2", p, 44);
    run_bit(-1, 3'b000, p, s, n, s1);
    chk("R7 next bit nominal", p, 36);
    configure(mk(3, 3, 1, 2, 2, 0));
    run_bit(2, 3'b000, p, s, n, s1);
    chk("R7 ph1 edge sjw4", p, 48);
    configure(mk(3, 1, 1, 2, 2, 0));
    run_bit(1, 3'b000, p, s, n, s1);
    chk("R7 prop edge length", p, 40);
    chk("R7 prop edge sample offset", s, 24);
  endtask

  task automatic t_resync_shorten;
    int p, s, n, s1;
    configure(mk(3, 0, 1, 2, 2, 0));
    run_bit(3, 3'b000, p, s, n, s1);
    chk("R8 ph2 edge sjw1", p, 32);
    configure(mk(3, 3, 1, 2, 2, 0));
    run_bit(3, 3'b000, p, s, n, s1);
    chk("R8 ph2 edge sjw4", p, 28);
  endtask

  task automatic t_sync_ignored;
    int p, s, n, s1;
    configure(mk(3, 3, 1, 2, 2, 0));
    run_bit(0, 3'b000, p, s, n, s1);
    run_bit(-1, 3'b000, p, s, n, s1);
    chk("R9 sync edge no effect", p, 36);
  endtask

  task automatic t_enable;
    int p, s, n, s1, ticks;
    configure(mk(3, 0, 1, 2, 2, 0));
    @(negedge clk); timing_word = mk(0, 0, 0, 0, 0, 0);
    run_bit(-1, 3'b000, p, s, n, s1);
    run_bit(-1, 3'b000, p, s, n, s1);
    chk("R10 change while enabled ignored", p, 36);
    @(negedge clk); enable = 1'b0;
    ticks = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tq_tick || seg != 2'd0) ticks++;
    end
    chk("R10 idle while disabled", ticks, 0);
    enable = 1'b1;
    run_bit(-1, 3'b000, p, s, n, s1);
    run_bit(-1, 3'b000, p, s, n, s1);
    chk("R10 new word after re-enable", p, 14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_clamp();
    t_max();
    t_triple();
    t_resync_lengthen();
    t_resync_shorten();
    t_sync_ignored();
    t_enable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule